// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the processor's half of taking an exception. When an exception request arrives with its vector number, it captures the status register, the supervisor stack pointer and the return address for that kind of exception. It then builds a two-word frame on the stack, looks up the handler address in a 256-entry vector table, and starts the first opcode fetch of the handler. The handler address becomes the new program counter. The lowered stack pointer becomes the new stack pointer. A one-cycle done pulse marks the end of the entry sequence.

All memory traffic uses one request/acknowledge bus with a single access outstanding. The table base is held in a base register, which keeps only the bits above a 1 MB boundary. After reset the block runs a boot entry instead of an exception: it writes no frame, reads the initial stack pointer and program counter from the first two table words, and fetches the first opcode. A bus error reported during any entry access stops the block in a halted state that only reset clears.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset is released, the block reads the word at address 0 into newSp, then the word at address 4 into newPc, then issues a read at that program counter. It writes nothing, and pulses done when that read is acknowledged.
- R2: An accepted request first writes the stacked PC to T-4 and then writes the format word to T-8, where T is ssp with its two low bits cleared. Once the sequence completes, newSp equals T-8.
- R3: The format word carries ssp[1:0] (the number of bytes dropped by alignment), zero-extended, in bits 31:28. Bits 27:26 are zero, the vector is in bits 25:18, bits 17:16 are zero, and statusReg is in bits 15:0.
- R4: The stacked PC is faultPc for vectors 2, 3, 4, 5, 8, 10, 11 and 14, and nextPc for every other vector.
- R5: After the frame, the block reads the vector table at {base[31:20], 10'b0, vector, 2'b00}. The word returned becomes newPc.
- R6: A vbrLoad pulse while idle sets the base to vbrValue with bits 19:0 forced to zero. If it falls in the same cycle as an accepted request, that exception already uses the new base. Reset clears the base to zero, and a vbrLoad pulse while busy has no effect.
- R7: After the vector read, the block reads at the handler address. The cycle after that read is acknowledged, done is high for exactly one cycle and busy is low.
- R8: A raised memReq keeps memAddr, memWe and memWdata stable until memAck or memErr arrives, and every write address is a multiple of 4.
- R9: A memErr on any entry access raises halt and holds it until reset. While halted, memReq stays low and done never pulses.
- R10: An excReq while busy, including during the boot entry, is ignored: it produces no extra bus access and does not change the results of the sequence in progress.
- R11: While reset is asserted, memReq, done and halt are low, busy is high, and newPc and newSp are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception request, sampled while idle |
| excVector | input | 8 | Vector number of the request |
| faultPc | input | 32 | Address of the faulting instruction |
| nextPc | input | 32 | Address of the next instruction |
| statusReg | input | 16 | Status register to be stacked |
| ssp | input | 32 | Current supervisor stack pointer |
| vbrLoad | input | 1 | Load strobe for the table base |
| vbrValue | input | 32 | New table base value |
| memReq | output | 1 | Bus access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Access address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access completed |
| memErr | input | 1 | Access failed |
| memRdata | input | 32 | Read data, valid with memAck |
| newPc | output | 32 | Handler or boot program counter |
| newSp | output | 32 | Updated stack pointer |
| done | output | 1 | One-cycle end-of-entry pulse |
| busy | output | 1 | Entry sequence or halt in progress |
| halt | output | 1 | Stopped after a bus error |

## Verification
A base-register load and an exception request can land in the same idle cycle. The bench provokes this by raising vbrLoad and excReq on one edge, and judges the result from the address of the vector read that follows, which must carry the newly loaded base. The bench also presents a second request and a second base load while a sequence is still running. It judges those by the count of bus accesses and by the base used in the next exception.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  parameter int XLEN       = 32;
  parameter int VEC_W      = 8;
  parameter int SR_W       = 16;
  parameter int FMT_W      = 4;
  parameter int BASE_LSB   = 20;
  parameter int WORD_BYTES = 4;
  parameter int FRAME_WORDS = 2;

  localparam int OFS_W       = $clog2(WORD_BYTES);
  localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;
  localparam int PAD_W       = BASE_LSB - VEC_W - OFS_W;
  localparam int GAP_LO      = 2;
  localparam int GAP_HI      = XLEN - FMT_W - VEC_W - SR_W - GAP_LO;
  localparam int BASE_W      = XLEN - BASE_LSB;
  localparam int NUM_VEC     = 1 << VEC_W;

  typedef enum logic [3:0] {
    ST_BOOT, ST_RST_SP, ST_RST_PC, ST_IDLE, ST_PUSH_PC,
    ST_PUSH_FMT, ST_VEC, ST_FETCH, ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    ASEL_TBL_SP, ASEL_TBL_PC, ASEL_PUSH_PC, ASEL_PUSH_FMT, ASEL_TBL_VEC, ASEL_FETCH
  } addr_sel_e;

  typedef struct packed {
    logic      capture;
    logic      ldSpFrame;
    logic      ldSpMem;
    logic      ldPcMem;
    logic      ldVbr;
    logic      wdFmt;
    addr_sel_e addrSel;
  } strobe_t;

  function automatic logic [NUM_VEC-1:0] faultMask();
    logic [NUM_VEC-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (i == 2 || i == 3 || i == 4 || i == 5 || i == 8 || i == 10 || i == 11 || i == 14)
        m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [NUM_VEC-1:0] FAULT_MASK = faultMask();
endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    excReq,
  input  logic    vbrLoad,
  input  logic    memAck,
  input  logic    memErr,
  output logic    memReq,
  output logic    memWe,
  output logic    done,
  output logic    busy,
  output logic    halt,
  output strobe_t strb
);
  seq_state_e state;
  seq_state_e nxt;
  seq_state_e succ;
  logic doneQ;
  logic respOk;

  assign respOk = memAck && !memErr;

  always_comb begin
    unique case (state)
      ST_RST_SP:   succ = ST_RST_PC;
      ST_RST_PC:   succ = ST_FETCH;
      ST_PUSH_PC:  succ = ST_PUSH_FMT;
      ST_PUSH_FMT: succ = ST_VEC;
      ST_VEC:      succ = ST_FETCH;
      ST_FETCH:    succ = ST_IDLE;
      default:     succ = state;
    endcase
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_BOOT: nxt = ST_RST_SP;
      ST_IDLE: if (excReq) nxt = ST_PUSH_PC;
      ST_HALT: nxt = ST_HALT;
      default: begin
        if (memErr)      nxt = ST_HALT;
        else if (memAck) nxt = succ;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_BOOT;
      doneQ <= 1'b0;
    end else begin
      state <= nxt;
      doneQ <= (state == ST_FETCH) && respOk;
    end
  end

  always_comb begin
    memReq = state inside {ST_RST_SP, ST_RST_PC, ST_PUSH_PC, ST_PUSH_FMT, ST_VEC, ST_FETCH};
    memWe  = state inside {ST_PUSH_PC, ST_PUSH_FMT};
    strb.capture   = (state == ST_IDLE) && excReq;
    strb.ldVbr     = (state == ST_IDLE) && vbrLoad;
    strb.ldSpMem   = (state == ST_RST_SP) && respOk;
    strb.ldPcMem   = (state inside {ST_RST_PC, ST_VEC}) && respOk;
    strb.ldSpFrame = (state == ST_PUSH_FMT) && respOk;
    strb.wdFmt     = (state == ST_PUSH_FMT);
    unique case (state)
      ST_RST_SP:   strb.addrSel = ASEL_TBL_SP;
      ST_RST_PC:   strb.addrSel = ASEL_TBL_PC;
      ST_PUSH_PC:  strb.addrSel = ASEL_PUSH_PC;
      ST_PUSH_FMT: strb.addrSel = ASEL_PUSH_FMT;
      ST_VEC:      strb.addrSel = ASEL_TBL_VEC;
      default:     strb.addrSel = ASEL_FETCH;
    endcase
  end

  assign done = doneQ;
  assign busy = (state != ST_IDLE);
  assign halt = (state == ST_HALT);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN) doneQ |=> !doneQ);

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) halt |=> halt && !memReq && !doneQ);

  // R10
  entry_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_PUSH_PC) || ($past(state) == ST_PUSH_PC));
endmodule

// File: rtl/exc_seq_dpath.sv
module exc_seq_dpath
  import exc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [VEC_W-1:0] excVector,
  input  logic [XLEN-1:0]  faultPc,
  input  logic [XLEN-1:0]  nextPc,
  input  logic [SR_W-1:0]  statusReg,
  input  logic [XLEN-1:0]  ssp,
  input  logic [XLEN-1:0]  vbrValue,
  input  logic [XLEN-1:0]  memRdata,
  input  logic             memReq,
  input  logic             memWe,
  input  logic             memAck,
  input  logic             memErr,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  output logic [XLEN-1:0]  newPc,
  output logic [XLEN-1:0]  newSp
);
  logic [VEC_W-1:0]  vecQ;
  logic [XLEN-1:0]   stPcQ;
  logic [SR_W-1:0]   srQ;
  logic [XLEN-1:0]   frameTopQ;
  logic [OFS_W-1:0]  dropQ;
  logic [XLEN-1:0]   spQ;
  logic [XLEN-1:0]   pcQ;
  logic [BASE_W-1:0] vbrQ;
  logic [XLEN-1:0]   fmtWord;

  function automatic logic [XLEN-1:0] tblAddr(input logic [BASE_W-1:0] base,
                                               input logic [VEC_W-1:0] v);
    return {base, {PAD_W{1'b0}}, v, {OFS_W{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ      <= '0;
      stPcQ     <= '0;
      srQ       <= '0;
      frameTopQ <= '0;
      dropQ     <= '0;
      spQ       <= '0;
      pcQ       <= '0;
      vbrQ      <= '0;
    end else begin
      if (strb.capture) begin
        vecQ      <= excVector;
        stPcQ     <= FAULT_MASK[excVector] ? faultPc : nextPc;
        srQ       <= statusReg;
        frameTopQ <= {ssp[XLEN-1:OFS_W], {OFS_W{1'b0}}};
        dropQ     <= ssp[OFS_W-1:0];
      end
      if (strb.ldVbr)     vbrQ <= vbrValue[XLEN-1:BASE_LSB];
      if (strb.ldSpMem)   spQ  <= memRdata;
      if (strb.ldSpFrame) spQ  <= frameTopQ - XLEN'(FRAME_BYTES);
      if (strb.ldPcMem)   pcQ  <= memRdata;
    end
  end

  assign fmtWord = {FMT_W'(dropQ), {GAP_HI{1'b0}}, vecQ, {GAP_LO{1'b0}}, srQ};

  always_comb begin
    unique case (strb.addrSel)
      ASEL_TBL_SP:   memAddr = tblAddr(vbrQ, VEC_W'(0));
      ASEL_TBL_PC:   memAddr = tblAddr(vbrQ, VEC_W'(1));
      ASEL_PUSH_PC:  memAddr = frameTopQ - XLEN'(WORD_BYTES);
      ASEL_PUSH_FMT: memAddr = frameTopQ - XLEN'(FRAME_BYTES);
      ASEL_TBL_VEC:  memAddr = tblAddr(vbrQ, vecQ);
      default:       memAddr = pcQ;
    endcase
    memWdata = strb.wdFmt ? fmtWord : stPcQ;
  end

  assign newPc = pcQ;
  assign newSp = spQ;

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr) |=> memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe));

  // R8
  write_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr[OFS_W-1:0] == '0));

  // R2
  frame_sp_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldSpFrame |=> (newSp[OFS_W-1:0] == '0));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             excReq,
  input  logic [VEC_W-1:0] excVector,
  input  logic [XLEN-1:0]  faultPc,
  input  logic [XLEN-1:0]  nextPc,
  input  logic [SR_W-1:0]  statusReg,
  input  logic [XLEN-1:0]  ssp,
  input  logic             vbrLoad,
  input  logic [XLEN-1:0]  vbrValue,
  output logic             memReq,
  output logic             memWe,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  input  logic             memAck,
  input  logic             memErr,
  input  logic [XLEN-1:0]  memRdata,
  output logic [XLEN-1:0]  newPc,
  output logic [XLEN-1:0]  newSp,
  output logic             done,
  output logic             busy,
  output logic             halt
);
  strobe_t strb;

  exc_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .excReq(excReq), .vbrLoad(vbrLoad),
    .memAck(memAck), .memErr(memErr), .memReq(memReq), .memWe(memWe),
    .done(done), .busy(busy), .halt(halt), .strb(strb)
  );

  exc_seq_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .excVector(excVector),
    .faultPc(faultPc), .nextPc(nextPc), .statusReg(statusReg), .ssp(ssp),
    .vbrValue(vbrValue), .memRdata(memRdata), .memReq(memReq), .memWe(memWe),
    .memAck(memAck), .memErr(memErr), .memAddr(memAddr), .memWdata(memWdata),
    .newPc(newPc), .newSp(newSp)
  );
endmodule

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic excReq;
  logic [7:0] excVector;
  logic [31:0] faultPc, nextPc, ssp, vbrValue;
  logic [15:0] statusReg;
  logic vbrLoad;
  logic memReq, memWe, memAck, memErr;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [31:0] newPc, newSp;
  logic done, busy, halt;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  int latency = 1;
  bit errEn = 0;
  logic [31:0] errAddr = '0;
  logic [31:0] initSp = 32'h0003_FFF4;
  logic [31:0] initPc = 32'h0000_0400;
  int waitCnt = 0;
  int txCount = 0;
  logic [31:0] txAddr [4096];
  logic [31:0] txData [4096];
  logic        txWe   [4096];

  logic [7:0]  eVec;
  logic [31:0] eFpc, eNpc, eSsp, eBase;
  logic [15:0] eSr;
  int eStart;

  always #5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excVector(excVector),
    .faultPc(faultPc), .nextPc(nextPc), .statusReg(statusReg), .ssp(ssp),
    .vbrLoad(vbrLoad), .vbrValue(vbrValue), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memErr(memErr),
    .memRdata(memRdata), .newPc(newPc), .newSp(newSp), .done(done),
    .busy(busy), .halt(halt)
  );

  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (a == 32'h0) return initSp;
    if (a == 32'h4) return initPc;
    return {a[15:0], a[31:16]} ^ 32'h0F0F_3C3C;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; memErr <= 1'b0; waitCnt <= 0; memRdata <= '0;
    end else if (memAck || memErr) begin
      memAck <= 1'b0; memErr <= 1'b0; waitCnt <= 0;
    end else if (memReq) begin
      if (waitCnt >= latency) begin
        if (txCount < 4096) begin
          txAddr[txCount] <= memAddr;
          txData[txCount] <= memWe ? memWdata : memRead(memAddr);
          txWe[txCount]   <= memWe;
        end
        txCount <= txCount + 1;
        if (errEn && memAddr == errAddr) memErr <= 1'b1;
        else begin
          memAck <= 1'b1;
          memRdata <= memRead(memAddr);
        end
      end else waitCnt <= waitCnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (done !== 1'b1 && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " done seen"}, {31'b0, done}, 32'h1);
  endtask

  function automatic bit isFault(input logic [7:0] v);
    return v inside {8'd2, 8'd3, 8'd4, 8'd5, 8'd8, 8'd10, 8'd11, 8'd14};
  endfunction

  function automatic logic [31:0] vecAddr(input logic [31:0] base, input logic [7:0] v);
    return {base[31:20], 10'b0, v, 2'b00};
  endfunction

  task automatic loadVbr(input logic [31:0] val);
    while (busy) @(negedge clk);
    vbrLoad = 1'b1; vbrValue = val;
    @(negedge clk);
    vbrLoad = 1'b0;
  endtask

  task automatic startExc(input logic [7:0] v, input logic [31:0] fpc, input logic [31:0] npc,
                          input logic [15:0] sr, input logic [31:0] sp, input logic [31:0] base,
                          input bit withVbr);
    while (busy) @(negedge clk);
    eVec = v; eFpc = fpc; eNpc = npc; eSr = sr; eSsp = sp; eBase = base;
    eStart = txCount;
    excReq = 1'b1; excVector = v; faultPc = fpc; nextPc = npc; statusReg = sr; ssp = sp;
    if (withVbr) begin vbrLoad = 1'b1; vbrValue = base; end
    @(negedge clk);
    excReq = 1'b0; vbrLoad = 1'b0;
    excVector = ~v; faultPc = ~fpc; nextPc = ~npc; ssp = ~sp;
  endtask

  task automatic finishExc();
    logic [31:0] top, sPc, fmt, va, hand;
    waitDone("R7");
    top  = {eSsp[31:2], 2'b00};
    sPc  = isFault(eVec) ? eFpc : eNpc;
    fmt  = {2'b00, eSsp[1:0], 2'b00, eVec, 2'b00, eSr};
    va   = vecAddr(eBase, eVec);
    hand = memRead(va);
    chk("R10 access count", txCount - eStart, 4);
    chk("R2 first write addr", txAddr[eStart], top - 4);
    chk("R4 stacked pc", txData[eStart], sPc);
    chk("R2 writes flagged", {30'b0, txWe[eStart], txWe[eStart+1]}, 32'h3);
    chk("R2 second write addr", txAddr[eStart+1], top - 8);
    chk("R3 format word", txData[eStart+1], fmt);
    chk("R5 vector read addr", {txWe[eStart+2], txAddr[eStart+2][30:0]}, {1'b0, va[30:0]});
    chk("R7 fetch addr", {txWe[eStart+3], txAddr[eStart+3][30:0]}, {1'b0, hand[30:0]});
    chk("R5 newPc", newPc, hand);
    chk("R2 newSp", newSp, top - 8);
    chk("R7 busy low", {31'b0, busy}, 32'h0);
    @(negedge clk);
    chk("R7 done one cycle", {31'b0, done}, 32'h0);
  endtask

  initial begin
    int lim;
    lim = 150000;
    repeat (lim) @(posedge clk);
    if (!finished) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [3];
    int s0;
    bit sawDone;
    bases[0] = 32'h0000_0000; bases[1] = 32'h00AB_CDEF; bases[2] = 32'hFFF7_1234;
    rstN = 1'b0; excReq = 1'b0; excVector = '0; faultPc = '0; nextPc = '0;
    statusReg = '0; ssp = '0; vbrLoad = 1'b0; vbrValue = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 memReq", {31'b0, memReq}, 0);
    chk("R11 done", {31'b0, done}, 0);
    chk("R11 halt", {31'b0, halt}, 0);
    chk("R11 busy", {31'b0, busy}, 1);
    chk("R11 newPc", newPc, 0);
    chk("R11 newSp", newSp, 0);

    // R1 boot entry, with a request during it (R10)
    s0 = txCount;
    rstN = 1'b1;
    @(negedge clk);
    excReq = 1'b1; excVector = 8'd4;
    @(negedge clk);
    excReq = 1'b0;
    waitDone("R1");
    chk("R1 access count", txCount - s0, 3);
    chk("R1 sp read addr", {txWe[s0], txAddr[s0][30:0]}, 32'h0);
    chk("R1 pc read addr", {txWe[s0+1], txAddr[s0+1][30:0]}, 32'h4);
    chk("R1 fetch addr", {txWe[s0+2], txAddr[s0+2][30:0]}, {1'b0, initPc[30:0]});
    chk("R1 newSp", newSp, initSp);
    chk("R1 newPc", newPc, initPc);

    // R4 R5 R6 sweep of all vectors over three bases and latencies
    for (int b = 0; b < 3; b++) begin
      if (b != 0) loadVbr(bases[b]);
      for (int v = 0; v < 256; v++) begin
        latency = (v + b) % 3;
        startExc(8'(v), 32'h1000_0000 + 32'(v * 4), 32'h2000_0002 + 32'(v * 8),
                 16'(v * 257), 32'h4000_0100 + 32'(v * 16) + 32'(v % 4), bases[b], 1'b0);
        finishExc();
      end
    end

    // R6 base load in the same cycle as a request
    latency = 1;
    startExc(8'd64, 32'hAAAA_0000, 32'hBBBB_0004, 16'h2700, 32'h0001_0007, 32'h7654_3210, 1'b1);
    finishExc();

    // R10 R6 second request and base load while busy are ignored
    startExc(8'd9, 32'hCAFE_0000, 32'hCAFE_0010, 16'h2004, 32'h0002_0002, 32'h7654_3210, 1'b0);
    @(negedge clk); @(negedge clk);
    excReq = 1'b1; excVector = 8'd4; faultPc = 32'h1; nextPc = 32'h2; ssp = 32'h100;
    vbrLoad = 1'b1; vbrValue = 32'h1110_0000;
    @(negedge clk);
    excReq = 1'b0; vbrLoad = 1'b0;
    finishExc();
    startExc(8'd5, 32'hDEAD_0000, 32'hDEAD_0008, 16'h2100, 32'h0003_0001, 32'h7654_3210, 1'b0);
    finishExc();

    // R9 bus error on the vector read halts
    errEn = 1'b1; errAddr = vecAddr(32'h7654_3210, 8'd3);
    startExc(8'd3, 32'h0BAD_0000, 32'h0BAD_0004, 16'h2000, 32'h0004_0000, 32'h7654_3210, 1'b0);
    sawDone = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) sawDone = 1;
    end
    chk("R9 halt high", {31'b0, halt}, 1);
    chk("R9 no done", {31'b0, sawDone}, 0);
    chk("R9 memReq low", {31'b0, memReq}, 0);
    chk("R9 access count", txCount - eStart, 3);
    repeat (10) @(negedge clk);
    chk("R9 halt held", {31'b0, halt}, 1);
    errEn = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 halt cleared by reset", {31'b0, halt}, 0);
    s0 = txCount;
    rstN = 1'b1;
    waitDone("R1 reboot");
    chk("R6 base cleared sp addr", txAddr[s0], 32'h0);
    chk("R1 reboot newPc", newPc, initPc);
    startExc(8'd70, 32'h3000_0000, 32'h3000_0004, 16'h0001, 32'h0005_0003, 32'h0, 1'b0);
    finishExc();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule